// File: doc/BRIEF.md
# SDRAM Burst Column and Data-Timing Sequencer

This block turns one accepted read or write command into the column addresses and data strobes of a single SDRAM burst. When a command is accepted, the block captures the start column, the burst-length code, the wrap order and the CAS latency from a mode-register image. It then presents one column per clock until the burst has run its length, a stop request arrives, or a newer command replaces it.

For writes, the block drives per-byte write enables in the same cycle as each write column. The byte mask is applied in that cycle with no delay. For reads, it raises a capture strobe exactly CAS-latency clocks after each read column. It also drives per-byte output enables that honour the byte mask as it stood two clocks before the data. Command sequencing, row handling, refresh and pad drivers belong to neighbouring blocks.

Top module: `sdram_burst_path`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle. In the cycle after reset, `col_valid`, `wr_byte_en`, `rd_capture` and `rd_byte_oe` are all zero.
- R2: A command taken at an edge (`cmd_valid` high) puts the start column `cmd_col` on `col_addr`, with `col_valid` high, in the next cycle. Each further beat of the burst follows one clock later, with no gap. `col_write` repeats `cmd_write` for every beat.
- R3: The burst-length code `cfg_bl_code` gives the number of beats: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives full page. A full-page burst runs over all 512 columns and wraps until it is stopped or replaced. Codes 4, 5 and 6 behave as length 1.
- R4: With `cfg_interleave` = 0 (sequential order), beat k of a burst of length BL uses the low log2(BL) bits ((start + k) mod BL). The upper column bits are kept from the start column.
- R5: With `cfg_interleave` = 1 (interleaved order), beat k uses the low log2(BL) bits (start XOR k). The upper column bits are kept from the start column.
- R6: `cmd_stop` high at an edge, with no command at that edge, ends the active burst, so `col_valid` is low in the next cycle. While the block is idle, `cmd_stop` has no effect.
- R7: A command that arrives while a burst is running cuts that burst short, and the new burst starts in the next cycle. A command and a stop at the same edge start the command.
- R8: Length, order, latency and direction are taken only at the edge where a command is accepted. Changes to `cfg_*` during a burst do not affect that burst.
- R9: With `cfg_cl3` = 0 the CAS latency is 2, and with 1 it is 3. `rd_capture` is high in the cycle that comes exactly that many clocks after each cycle showing a read column.
- R10: In a cycle with a write column, `wr_byte_en` = ~`mask_in` of the same cycle. Without a write column, it is zero.
- R11: In a cycle where `rd_capture` is high, `rd_byte_oe` = ~(`mask_in` as it stood two cycles before). Otherwise it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_bl_code | input | 3 | Burst-length code from the mode image |
| cfg_interleave | input | 1 | 1 selects interleaved wrap order |
| cfg_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cmd_valid | input | 1 | Start a burst at this edge |
| cmd_write | input | 1 | Direction of the command, 1 = write |
| cmd_col | input | 9 | Start column |
| cmd_stop | input | 1 | Terminate the active burst |
| mask_in | input | 4 | Per-byte data mask, 1 = masked |
| col_valid | output | 1 | A column beat is presented this cycle |
| col_addr | output | 9 | Column of the current beat |
| col_write | output | 1 | Current beat is a write |
| wr_byte_en | output | 4 | Per-byte write data enable |
| rd_capture | output | 1 | Read data is due at this cycle |
| rd_byte_oe | output | 4 | Per-byte enable for read data |

## Verification
If the beat counter or the captured start column goes wrong, the very next `col_addr` differs from the expected wrap sequence, one cycle after the fault. A wrong burst-end decision shows up as a beat that is missing or extra, which appears on `col_valid` in the cycle it happens. Faults in the latency or mask pipelines do not show until two or three cycles later, as a `rd_capture` or `rd_byte_oe` that is displaced or wrong. For that reason the reference model tracks the column history and the mask history separately and compares all outputs on every cycle.

// File: rtl/sdram_bp_pkg.sv
// Shared definitions for the burst sequencer: burst-length codes and the
// per-burst mode captured when a command is accepted.
package sdram_bp_pkg;

    typedef enum logic [2:0] {
        BL_ONE   = 3'd0,
        BL_TWO   = 3'd1,
        BL_FOUR  = 3'd2,
        BL_EIGHT = 3'd3,
        BL_PAGE  = 3'd7
    } bl_code_e;

    typedef struct packed {
        logic full;
        logic interleave;
        logic cl3;
        logic write;
    } burst_mode_t;

endpackage

// File: rtl/sdram_bp_seq.sv
// Burst state holder. Captures the start column and mode on a command, then
// steps a beat counter once per clock until the length is reached, a stop
// arrives, or a new command replaces the burst.
// Assumes: COL_W >= 3; a full-page burst runs until stopped or replaced.
module sdram_bp_seq
    import sdram_bp_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [2:0]       cfg_bl_code,
    input  logic             cfg_interleave,
    input  logic             cfg_cl3,
    output logic             act,
    output logic [COL_W-1:0] start,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] len_mask,
    output burst_mode_t      mode
);

    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic             last_beat;

    // Decode the length code into a wrap mask (BL-1) and a full-page flag.
    always_comb begin
        dec_full = 1'b0;
        case (cfg_bl_code)
            BL_TWO:   dec_mask = COL_W'(1);
            BL_FOUR:  dec_mask = COL_W'(3);
            BL_EIGHT: dec_mask = COL_W'(7);
            BL_PAGE: begin
                dec_mask = '1;
                dec_full = 1'b1;
            end
            default:  dec_mask = '0;
        endcase
    end

    // The last beat of a fixed-length burst is reached when the counter
    // equals BL-1.
    assign last_beat = !mode.full && (cnt == len_mask);

    // Burst activity and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            cnt <= '0;
        end else if (cmd_valid) begin
            act <= 1'b1;
            cnt <= '0;
        end else if (cmd_stop) begin
            act <= 1'b0;
        end else if (act) begin
            if (last_beat) begin
                act <= 1'b0;
            end else begin
                cnt <= cnt + COL_W'(1);
            end
        end
    end

    // Capture the start column and burst mode on a command only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start    <= '0;
            len_mask <= '0;
            mode     <= '0;
        end else if (cmd_valid) begin
            start           <= cmd_col;
            len_mask        <= dec_mask;
            mode.full       <= dec_full;
            mode.interleave <= cfg_interleave;
            mode.cl3        <= cfg_cl3;
            mode.write      <= cmd_write;
        end
    end

endmodule

// File: rtl/sdram_bp_colgen.sv
// Column generator. Combines the held upper bits of the start column with a
// wrapped low offset, which is sequential (add) or interleaved (xor).
// Assumes: len_mask is of the form 2^n - 1.
module sdram_bp_colgen #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] len_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] off_seq;
    logic [COL_W-1:0] off_il;

    // Form both wrap orders and select the one the burst asks for.
    always_comb begin
        off_seq = (start + cnt) & len_mask;
        off_il  = (start ^ cnt) & len_mask;
        col     = (start & ~len_mask) | (interleave ? off_il : off_seq);
    end

endmodule

// File: rtl/sdram_bp_latpipe.sv
// Read timing pipes. There is one shift chain per supported CAS latency. A
// read beat enters the chain that matches its latency and leaves it as the
// capture strobe. A separate chain delays the byte mask by the read mask
// latency.
// Assumes: MIN_CL >= 2 and RD_MASK_LAT >= 1.
module sdram_bp_latpipe #(
    parameter int MASK_W      = 4,
    parameter int MIN_CL      = 2,
    parameter int MAX_CL      = 3,
    parameter int RD_MASK_LAT = 2,
    localparam int LAT_W      = $clog2(MAX_CL + 1),
    localparam int NLAT       = MAX_CL - MIN_CL + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_beat,
    input  logic [LAT_W-1:0]  beat_lat,
    input  logic [MASK_W-1:0] mask_in,
    output logic              rd_capture,
    output logic [MASK_W-1:0] rd_byte_oe
);

    logic [NLAT-1:0]   hit;
    logic [MASK_W-1:0] mpipe [RD_MASK_LAT];

    for (genvar L = MIN_CL; L <= MAX_CL; L++) begin : g_lat
        logic [L-1:0] sh;
        logic         sel;
        assign sel = (int'(beat_lat) == L);
        // Carry a read beat of this latency forward one stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh <= {sh[L-2:0], rd_beat & sel};
            end
        end
        assign hit[L-MIN_CL] = sh[L-1];
    end

    // Delay the byte mask by the read mask latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RD_MASK_LAT; i++) mpipe[i] <= '0;
        end else begin
            mpipe[0] <= mask_in;
            for (int i = 1; i < RD_MASK_LAT; i++) mpipe[i] <= mpipe[i-1];
        end
    end

    assign rd_capture = |hit;
    assign rd_byte_oe = rd_capture ? ~mpipe[RD_MASK_LAT-1] : '0;

endmodule

// File: rtl/sdram_burst_path.sv
// Top of the burst sequencer. The sequencer produces one column per clock.
// Write enables take the mask of the same cycle. Read strobes are delayed by
// the CAS latency captured for the burst.
// Assumes: the command source follows the SDRAM timing rules; this block
// only sequences a single burst.
module sdram_burst_path
    import sdram_bp_pkg::*;
#(
    parameter int COL_W       = 9,
    parameter int MASK_W      = 4,
    parameter int RD_MASK_LAT = 2,
    localparam int MIN_CL     = 2,
    localparam int MAX_CL     = 3,
    localparam int LAT_W      = $clog2(MAX_CL + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_bl_code,
    input  logic              cfg_interleave,
    input  logic              cfg_cl3,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [COL_W-1:0]  cmd_col,
    input  logic              cmd_stop,
    input  logic [MASK_W-1:0] mask_in,
    output logic              col_valid,
    output logic [COL_W-1:0]  col_addr,
    output logic              col_write,
    output logic [MASK_W-1:0] wr_byte_en,
    output logic              rd_capture,
    output logic [MASK_W-1:0] rd_byte_oe
);

    logic             act;
    logic [COL_W-1:0] start;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] len_mask;
    burst_mode_t      mode;
    logic [LAT_W-1:0] beat_lat;

    sdram_bp_seq #(.COL_W(COL_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_col        (cmd_col),
        .cmd_stop       (cmd_stop),
        .cfg_bl_code    (cfg_bl_code),
        .cfg_interleave (cfg_interleave),
        .cfg_cl3        (cfg_cl3),
        .act            (act),
        .start          (start),
        .cnt            (cnt),
        .len_mask       (len_mask),
        .mode           (mode)
    );

    sdram_bp_colgen #(.COL_W(COL_W)) u_colgen (
        .start      (start),
        .cnt        (cnt),
        .len_mask   (len_mask),
        .interleave (mode.interleave),
        .col        (col_addr)
    );

    assign beat_lat = mode.cl3 ? LAT_W'(MAX_CL) : LAT_W'(MIN_CL);

    sdram_bp_latpipe #(
        .MASK_W      (MASK_W),
        .MIN_CL      (MIN_CL),
        .MAX_CL      (MAX_CL),
        .RD_MASK_LAT (RD_MASK_LAT)
    ) u_latpipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_beat    (act && !mode.write),
        .beat_lat   (beat_lat),
        .mask_in    (mask_in),
        .rd_capture (rd_capture),
        .rd_byte_oe (rd_byte_oe)
    );

    assign col_valid  = act;
    assign col_write  = mode.write;
    assign wr_byte_en = (act && mode.write) ? ~mask_in : '0;

endmodule

// File: rtl/sdram_burst_path_chk.sv
// Temporal checks on the burst sequencer ports, attached by bind.
module sdram_burst_path_chk #(
    parameter int COL_W  = 9,
    parameter int MASK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [COL_W-1:0]  cmd_col,
    input logic              cmd_stop,
    input logic              col_valid,
    input logic [COL_W-1:0]  col_addr,
    input logic              col_write,
    input logic [MASK_W-1:0] wr_byte_en,
    input logic              rd_capture,
    input logic [MASK_W-1:0] rd_byte_oe
);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !col_valid && !rd_capture);

    // R2
    first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> col_valid && (col_addr == $past(cmd_col)));

    // R6
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_valid) |=> !col_valid);

    // R9
    capture_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_capture |-> ($past(col_valid && !col_write, 2) || $past(col_valid && !col_write, 3)));

    // R10
    wr_en_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_en != '0) |-> (col_valid && col_write));

    // R11
    oe_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_byte_oe != '0) |-> rd_capture);

endmodule

bind sdram_burst_path sdram_burst_path_chk #(.COL_W(COL_W), .MASK_W(MASK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_col    (cmd_col),
    .cmd_stop   (cmd_stop),
    .col_valid  (col_valid),
    .col_addr   (col_addr),
    .col_write  (col_write),
    .wr_byte_en (wr_byte_en),
    .rd_capture (rd_capture),
    .rd_byte_oe (rd_byte_oe)
);

// File: tb/sdram_burst_path_tb.sv
module sdram_burst_path_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_bl_code = '0;
    logic       cfg_interleave = 1'b0;
    logic       cfg_cl3 = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [8:0] cmd_col = '0;
    logic       cmd_stop = 1'b0;
    logic [3:0] mask_in = '0;
    logic       col_valid;
    logic [8:0] col_addr;
    logic       col_write;
    logic [3:0] wr_byte_en;
    logic       rd_capture;
    logic [3:0] rd_byte_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 8;
    int wd = 0;
    logic [3:0] mask_pat = 4'b1001;

    // Behavioural reference state.
    int m_act = 0, m_start = 0, m_cnt = 0, m_len = 1, m_full = 0;
    int m_il = 0, m_cl3 = 0, m_wr = 0;
    bit rd2h [8];
    bit rd3h [8];
    int mh   [8];

    always #2 clk = ~clk;

    sdram_burst_path u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bl_code(cfg_bl_code),
        .cfg_interleave(cfg_interleave), .cfg_cl3(cfg_cl3),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_col(cmd_col),
        .cmd_stop(cmd_stop), .mask_in(mask_in), .col_valid(col_valid),
        .col_addr(col_addr), .col_write(col_write), .wr_byte_en(wr_byte_en),
        .rd_capture(rd_capture), .rd_byte_oe(rd_byte_oe)
    );

    function automatic int len_of(input int code);
        case (code)
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 512;
            default: return 1;
        endcase
    endfunction

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_cnt = 0;
        end else if (cmd_valid) begin
            m_act = 1; m_cnt = 0; m_start = int'(cmd_col);
            m_len = len_of(int'(cfg_bl_code)); m_full = (cfg_bl_code == 3'd7);
            m_il = int'(cfg_interleave); m_cl3 = int'(cfg_cl3); m_wr = int'(cmd_write);
        end else if (cmd_stop) begin
            m_act = 0;
        end else if (m_act != 0) begin
            if (m_full == 0 && m_cnt == m_len - 1) m_act = 0;
            else m_cnt = (m_cnt + 1) % 512;
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", wd, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model for the current cycle.
    task automatic compare(input string tag);
        int idx, low, off, exp_addr, capt, oe;
        idx = cyc % 8;
        chk(tag, "col_valid", int'(col_valid), m_act);
        if (m_act != 0) begin
            low = m_start % m_len;
            off = (m_il != 0) ? (low ^ m_cnt) : ((low + m_cnt) % m_len);
            exp_addr = m_start - low + off;
            chk((m_il != 0) ? "R5" : "R4", "col_addr", int'(col_addr), exp_addr);
            chk("R2", "col_write", int'(col_write), m_wr);
        end
        chk("R10", "wr_byte_en", int'(wr_byte_en),
            (m_act != 0 && m_wr != 0) ? int'(~mask_in & 4'hF) : 0);
        rd2h[idx] = rst_n && m_act != 0 && m_wr == 0 && m_cl3 == 0;
        rd3h[idx] = rst_n && m_act != 0 && m_wr == 0 && m_cl3 != 0;
        mh[idx]   = rst_n ? int'(mask_in) : 0;
        capt = (rd2h[(cyc - 2) % 8] || rd3h[(cyc - 3) % 8]) ? 1 : 0;
        chk("R9", "rd_capture", int'(rd_capture), capt);
        oe = (capt != 0) ? ((~mh[(cyc - 2) % 8]) & 15) : 0;
        chk("R11", "rd_byte_oe", int'(rd_byte_oe), oe);
        cyc++;
    endtask

    task automatic step(input bit v, input bit w, input int col, input bit stp, input string tag);
        @(negedge clk);
        cmd_valid = v; cmd_write = w; cmd_col = 9'(col); cmd_stop = stp;
        mask_in = mask_pat;
        mask_pat = {mask_pat[2:0], mask_pat[3] ^ mask_pat[2]};
        #1 compare(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0, tag);
    endtask

    task automatic cfg(input int bl, input bit il, input bit cl3);
        cfg_bl_code = 3'(bl); cfg_interleave = il; cfg_cl3 = cl3;
    endtask

    initial begin
        idle(3, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 1'b0, "R1");
        chk("R1", "col_valid after reset", int'(col_valid), 0);
        // Sequential BL4 read, CL2, start mid-group.
        cfg(2, 1'b0, 1'b0);
        step(1'b1, 1'b0, 5, 1'b0, "R2");
        idle(7, "R3");
        // Interleaved BL8 write near the top of the column space.
        cfg(3, 1'b1, 1'b1);
        step(1'b1, 1'b1, 9'h1F3, 1'b0, "R5");
        idle(9, "R3");
        // BL1, BL2 interleaved, and a reserved code.
        cfg(0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 9'h0AA, 1'b0, "R3");
        idle(4, "R3");
        cfg(1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 7, 1'b0, "R3");
        idle(5, "R3");
        cfg(5, 1'b0, 1'b1);
        step(1'b1, 1'b0, 9'h155, 1'b0, "R3");
        idle(5, "R3");
        // Full-page sequential read, wrap past 511, then stop.
        cfg(7, 1'b0, 1'b0);
        step(1'b1, 1'b0, 510, 1'b0, "R3");
        idle(520, "R3");
        step(1'b0, 1'b0, 0, 1'b1, "R6");
        idle(4, "R6");
        // Full-page interleaved read, replaced by a new command.
        cfg(7, 1'b1, 1'b1);
        step(1'b1, 1'b0, 9'h0AB, 1'b0, "R5");
        idle(20, "R5");
        cfg(3, 1'b0, 1'b0);
        step(1'b1, 1'b0, 9'h040, 1'b0, "R7");
        idle(10, "R7");
        // Stop in the middle of BL8, then a stop while idle.
        cfg(3, 1'b0, 1'b1);
        step(1'b1, 1'b0, 9'h010, 1'b0, "R6");
        idle(2, "R6");
        step(1'b0, 1'b0, 0, 1'b1, "R6");
        idle(5, "R6");
        step(1'b0, 1'b0, 0, 1'b1, "R6");
        chk("R6", "idle stop", int'(col_valid), 0);
        idle(2, "R6");
        // Command and stop together: the command wins.
        step(1'b1, 1'b1, 9'h022, 1'b1, "R7");
        idle(10, "R7");
        // Config change during a burst has no effect.
        cfg(3, 1'b0, 1'b0);
        step(1'b1, 1'b0, 9'h033, 1'b0, "R8");
        cfg(0, 1'b1, 1'b1);
        idle(10, "R8");
        // Back-to-back reads at both latencies.
        cfg(0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, i * 3, 1'b0, "R9");
        cfg(2, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, i[0], 100 + i, 1'b0, "R9");
        idle(8, "R9");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule